// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Reader

This block holds a configuration bitstream in a byte array and plays it out to a device that is loading its configuration. In serial mode it presents one bit per clock on data lane 0. In parallel mode it presents one byte per clock on all eight lanes. The value for the current position is shown combinationally from the position registers. It therefore appears just after each rising clock edge, and the receiver captures it on the next rising edge. Each output lane has its own enable bit, and an enable of zero stands for a floating (high-impedance) pin.

Two inputs gate the stream. The chip-enable `ce_n` is active low. The output-enable `oe_rst` is active high, and when it is low it also acts as a reset. If either input is inactive, the position is held at the start and every lane floats. When the last bit or byte has been presented, the next clock moves the block into its handed-off state. There it floats its lanes and pulls `ce_out_n` low. That signal feeds the chip-enable of the next reader in a chain, so several readers can share one data bus and one clock.

The sequencer has two named states. `ST_SEND` presents data and advances the position. `ST_PASSED` holds the position frozen and hands off. The transition `ST_SEND -> ST_PASSED` is taken on the clock edge at which the position equals the terminal count. `ST_PASSED` loops on itself. Both states drop back to `ST_SEND` at position zero, asynchronously, whenever `ce_n` is high or `oe_rst` is low (the hold condition). The byte array is filled through a small write port, which is how a testbench or loader sets its contents.

Top module: `cfg_stream_reader`

## Requirements
- R1: Each rising clock edge that occurs while `ce_n` is low, `oe_rst` is high and the state is `ST_SEND` advances the position by one, unless the position is already at terminal count. In serial mode the position is one bit; in parallel mode it is one byte. Releasing the hold shows the first position with no clock edge needed.
- R2: While `oe_rst` is low, the position is held at zero, `data_oe` is 8'h00 and `ce_out_n` is high, whatever the clock does.
- R3: While `ce_n` is high, the position is held at zero, `data_oe` is 8'h00 and `ce_out_n` is high, whatever the level of `oe_rst`.
- R4: Terminal count is position `DEPTH*8-1` in serial mode and `DEPTH-1` in parallel mode. The clock edge taken at terminal count drives `ce_out_n` low and `data_oe` to 8'h00. Later edges change neither, and they do not change the position.
- R5: `ce_out_n` is low only when `ce_n` is low, `oe_rst` is high and the block has handed off. Pulling `oe_rst` low clears the hand-off, so `ce_out_n` is high again when `oe_rst` returns high, and the stream restarts at its first position.
- R6: Serial mode (`par_mode` = 0) puts the current bit on `data_o[0]` with `data_oe` = 8'h01 and `data_o[7:1]` = 0. Bits are sent most significant first within a byte, and bytes are sent in ascending address order.
- R7: Parallel mode (`par_mode` = 1) puts the whole byte at the current address on `data_o[7:0]`, with `data_oe` = 8'hFF and bytes in ascending address order.
- R8: When `fill_en` is high at a rising clock edge, `fill_data` is written to byte `fill_addr` of the array, and later streams present the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Stream clock; also clocks the fill port |
| ce_n | input | 1 | Chip-enable, active low; high means standby and a held position |
| oe_rst | input | 1 | Output-enable, active high; low floats the outputs and resets the position |
| par_mode | input | 1 | 0 selects serial output, 1 selects parallel output; must stay stable during a stream |
| fill_en | input | 1 | Array write strobe |
| fill_addr | input | ADDR_W | Array write byte address |
| fill_data | input | 8 | Array write byte |
| data_o | output | 8 | Output data lanes |
| data_oe | output | 8 | Per-lane drive enable; 0 means floating |
| ce_out_n | output | 1 | Cascade enable for the next reader, active low |

## Verification
The bench aims at the edges of the stream. It checks the first position, which must appear the moment the hold is released. A design that counted on the release edge would lose bit 0 or byte 0. It checks that the last position is presented for exactly one cycle before the hand-off. An off-by-one terminal count would either cut the last bit or repeat it before `ce_out_n` falls. Hand-off recovery is exercised by dropping `oe_rst` and then `ce_n` after `ce_out_n` has fallen. A design that kept the handed-off state across the reset would leave the next reader enabled and its own lanes silent. Serial bit order is compared against bytes that are not symmetric, so sending the least significant bit first shows up at once.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = 3;

    typedef enum logic [0:0] {
        ST_SEND   = 1'b0,
        ST_PASSED = 1'b1
    } seq_state_t;

endpackage

// File: rtl/cfg_stream_mem.sv
module cfg_stream_mem #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                              clk,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [cfg_stream_pkg::BYTE_W-1:0] wr_byte,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [cfg_stream_pkg::BYTE_W-1:0] rd_byte
);

    logic [cfg_stream_pkg::BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_byte;
        end
    end

    // Combinational read: the byte for the current position shows
    // right after the edge that moved the position.
    assign rd_byte = store[rd_addr];

endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 hold,
    input  logic                 par_mode,
    output seq_state_t           state,
    output logic [ADDR_W-1:0]    byte_addr,
    output logic [BIT_IDX_W-1:0] bit_idx
);

    localparam logic [ADDR_W-1:0]    LAST_BYTE = ADDR_W'(DEPTH - 1);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT  = '1;

    seq_state_t state_nx;
    logic       at_last;
    logic       byte_step;

    assign at_last   = (byte_addr == LAST_BYTE) && (par_mode || (bit_idx == LAST_BIT));
    assign byte_step = par_mode || (bit_idx == LAST_BIT);

    // State register: hold is an asynchronous level reset.
    always_ff @(posedge clk or posedge hold) begin
        if (hold) begin
            state <= ST_SEND;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SEND:   state_nx = at_last ? ST_PASSED : ST_SEND;
            ST_PASSED: state_nx = ST_PASSED;
            default:   state_nx = ST_SEND;
        endcase
    end

    // Position counters: advance only while sending and short of the end.
    always_ff @(posedge clk or posedge hold) begin
        if (hold) begin
            byte_addr <= '0;
            bit_idx   <= '0;
        end else if (state == ST_SEND && !at_last) begin
            if (byte_step) begin
                byte_addr <= byte_addr + ADDR_W'(1);
                bit_idx   <= '0;
            end else begin
                bit_idx   <= bit_idx + BIT_IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/cfg_stream_outmux.sv
module cfg_stream_outmux
    import cfg_stream_pkg::*;
(
    input  logic                 active,
    input  seq_state_t           state,
    input  logic                 par_mode,
    input  logic [BYTE_W-1:0]    rd_byte,
    input  logic [BIT_IDX_W-1:0] bit_idx,
    output logic [BYTE_W-1:0]    data_o,
    output logic [BYTE_W-1:0]    data_oe,
    output logic                 ce_out_n
);

    logic drive;
    logic ser_bit;

    always_comb begin
        drive    = 1'b0;
        ce_out_n = 1'b1;
        unique case (state)
            ST_SEND:   drive    = active;
            ST_PASSED: ce_out_n = ~active;
            default:   drive    = 1'b0;
        endcase
    end

    // Most significant bit first within each byte.
    assign ser_bit = rd_byte[BIT_IDX_W'(BYTE_W - 1) - bit_idx];

    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        if (g == 0) begin : g_lane0
            assign data_oe[g] = drive;
            assign data_o[g]  = drive & (par_mode ? rd_byte[g] : ser_bit);
        end else begin : g_laneN
            assign data_oe[g] = drive & par_mode;
            assign data_o[g]  = drive & par_mode & rd_byte[g];
        end
    end

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              ce_n,
    input  logic              oe_rst,
    input  logic              par_mode,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [BYTE_W-1:0] fill_data,
    output logic [BYTE_W-1:0] data_o,
    output logic [BYTE_W-1:0] data_oe,
    output logic              ce_out_n
);

    logic                 hold;
    seq_state_t           state;
    logic [ADDR_W-1:0]    byte_addr;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [BYTE_W-1:0]    rd_byte;

    assign hold = ce_n | ~oe_rst;

    cfg_stream_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_en   (fill_en),
        .wr_addr (fill_addr),
        .wr_byte (fill_data),
        .rd_addr (byte_addr),
        .rd_byte (rd_byte)
    );

    cfg_stream_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .hold      (hold),
        .par_mode  (par_mode),
        .state     (state),
        .byte_addr (byte_addr),
        .bit_idx   (bit_idx)
    );

    cfg_stream_outmux u_out (
        .active   (~hold),
        .state    (state),
        .par_mode (par_mode),
        .rd_byte  (rd_byte),
        .bit_idx  (bit_idx),
        .data_o   (data_o),
        .data_oe  (data_oe),
        .ce_out_n (ce_out_n)
    );

endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              ce_n,
    input logic              oe_rst,
    input logic              par_mode,
    input logic [7:0]        data_oe,
    input logic              ce_out_n,
    input logic [ADDR_W-1:0] byte_addr
);

    logic hold;
    assign hold = ce_n | ~oe_rst;

    always @(negedge clk) begin
        if (!oe_rst) begin
            assert_float_in_reset_R2: assert (data_oe == 8'h00 && ce_out_n);
        end
        if (ce_n) begin
            assert_float_in_standby_R3: assert (data_oe == 8'h00 && ce_out_n);
        end
    end

    assert_handoff_floats_R5: assert property (@(negedge clk) disable iff (hold)
        !ce_out_n |-> data_oe == 8'h00);

    assert_handoff_sticks_R4: assert property (@(posedge clk) disable iff (hold)
        !ce_out_n |=> !ce_out_n);

    assert_frozen_position_R4: assert property (@(posedge clk) disable iff (hold)
        !ce_out_n |=> $stable(byte_addr));

    assert_serial_lane0_R6: assert property (@(negedge clk) disable iff (hold)
        (!par_mode && data_oe != 8'h00) |-> data_oe == 8'h01);

    assert_parallel_all_lanes_R7: assert property (@(negedge clk) disable iff (hold)
        (par_mode && data_oe != 8'h00) |-> data_oe == 8'hFF);

endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .ce_n      (ce_n),
    .oe_rst    (oe_rst),
    .par_mode  (par_mode),
    .data_oe   (data_oe),
    .ce_out_n  (ce_out_n),
    .byte_addr (byte_addr)
);

// File: tb/cfg_stream_reader_test.sv
module cfg_stream_reader_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 6;
    localparam int ADDR_W     = $clog2(DEPTH);
    localparam int NBITS      = DEPTH * 8;

    logic              clk = 1'b0;
    logic              ce_n = 1'b1;
    logic              oe_rst = 1'b0;
    logic              par_mode = 1'b0;
    logic              fill_en = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [7:0]        fill_data = '0;
    logic [7:0]        data_o;
    logic [7:0]        data_oe;
    logic              ce_out_n;

    logic [7:0] exp_mem [DEPTH];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_stream_reader #(.DEPTH(DEPTH)) uut (
        .clk       (clk),
        .ce_n      (ce_n),
        .oe_rst    (oe_rst),
        .par_mode  (par_mode),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .data_o    (data_o),
        .data_oe   (data_oe),
        .ce_out_n  (ce_out_n)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input int k);
        return exp_mem[k / 8][7 - (k % 8)];
    endfunction

    task automatic go_hold();
        @(negedge clk);
        ce_n   = 1'b1;
        oe_rst = 1'b0;
    endtask

    task automatic release_stream(input logic par);
        @(negedge clk);
        par_mode = par;
        ce_n     = 1'b0;
        oe_rst   = 1'b1;
        #1;
    endtask

    task automatic t_fill_R8();
        for (int i = 0; i < DEPTH; i++) begin
            exp_mem[i] = 8'((i * 37 + 8'h5B) ^ (i << 4));
            @(negedge clk);
            fill_en   = 1'b1;
            fill_addr = ADDR_W'(i);
            fill_data = exp_mem[i];
        end
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic t_reset_R2();
        @(negedge clk);
        ce_n   = 1'b0;
        oe_rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R2 reset data_oe", 16'(data_oe), 16'h00);
        chk("R2 reset ce_out_n", 16'(ce_out_n), 16'h1);
    endtask

    task automatic t_standby_R3();
        @(negedge clk);
        ce_n   = 1'b1;
        oe_rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R3 standby data_oe", 16'(data_oe), 16'h00);
        chk("R3 standby ce_out_n", 16'(ce_out_n), 16'h1);
    endtask

    task automatic t_serial_R6();
        go_hold();
        release_stream(1'b0);
        for (int k = 0; k < NBITS; k++) begin
            if (k > 0) begin
                @(negedge clk);
                #1;
            end
            chk("R6 serial bit", 16'(data_o[0]), 16'(exp_bit(k)));
            chk("R6 serial enable", 16'(data_oe), 16'h01);
            chk("R6 upper lanes", 16'(data_o[7:1]), 16'h0);
            chk("R1 ce_out_n high while sending", 16'(ce_out_n), 16'h1);
        end
        @(negedge clk);
        #1;
        chk("R4 serial handoff ce_out_n", 16'(ce_out_n), 16'h0);
        chk("R4 serial handoff float", 16'(data_oe), 16'h00);
        repeat (4) @(negedge clk);
        #1;
        chk("R4 frozen ce_out_n", 16'(ce_out_n), 16'h0);
        chk("R4 frozen float", 16'(data_oe), 16'h00);
        @(negedge clk);
        ce_n = 1'b1;
        #1;
        chk("R5 ce_n high clears ce_out_n", 16'(ce_out_n), 16'h1);
    endtask

    task automatic run_parallel_to_end();
        go_hold();
        release_stream(1'b1);
        for (int a = 0; a < DEPTH; a++) begin
            if (a > 0) begin
                @(negedge clk);
                #1;
            end
            chk("R7 parallel byte", 16'(data_o), 16'(exp_mem[a]));
            chk("R7 parallel enable", 16'(data_oe), 16'hFF);
        end
        @(negedge clk);
        #1;
        chk("R4 parallel handoff ce_out_n", 16'(ce_out_n), 16'h0);
        chk("R4 parallel handoff float", 16'(data_oe), 16'h00);
    endtask

    task automatic t_parallel_R7();
        run_parallel_to_end();
    endtask

    task automatic t_oe_after_handoff_R5();
        run_parallel_to_end();
        @(negedge clk);
        oe_rst = 1'b0;
        #1;
        chk("R5 oe low ce_out_n", 16'(ce_out_n), 16'h1);
        repeat (2) @(negedge clk);
        #1;
        chk("R5 oe low held ce_out_n", 16'(ce_out_n), 16'h1);
        chk("R2 oe low float", 16'(data_oe), 16'h00);
        @(negedge clk);
        oe_rst = 1'b1;
        #1;
        chk("R5 oe back ce_out_n", 16'(ce_out_n), 16'h1);
        chk("R5 restart first byte", 16'(data_o), 16'(exp_mem[0]));
        chk("R5 restart enable", 16'(data_oe), 16'hFF);
    endtask

    task automatic t_midstream_reset_R1();
        go_hold();
        release_stream(1'b0);
        repeat (5) @(negedge clk);
        #1;
        chk("R1 serial position 5", 16'(data_o[0]), 16'(exp_bit(5)));
        oe_rst = 1'b0;
        #1;
        chk("R2 mid-stream float", 16'(data_oe), 16'h00);
        @(negedge clk);
        @(negedge clk);
        oe_rst = 1'b1;
        #1;
        chk("R2 position back to 0", 16'(data_o[0]), 16'(exp_bit(0)));
        @(negedge clk);
        #1;
        chk("R1 advance to 1", 16'(data_o[0]), 16'(exp_bit(1)));
        ce_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b0;
        #1;
        chk("R3 ce_n pulse resets position", 16'(data_o[0]), 16'(exp_bit(0)));
    endtask

    task automatic t_refill_R8();
        go_hold();
        exp_mem[0] = 8'hC3 ^ exp_mem[0];
        @(negedge clk);
        fill_en   = 1'b1;
        fill_addr = '0;
        fill_data = exp_mem[0];
        @(negedge clk);
        fill_en = 1'b0;
        release_stream(1'b1);
        chk("R8 rewritten byte 0", 16'(data_o), 16'(exp_mem[0]));
        @(negedge clk);
        #1;
        chk("R8 byte 1 unchanged", 16'(data_o), 16'(exp_mem[1]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        t_fill_R8();
        t_reset_R2();
        t_standby_R3();
        t_serial_R6();
        t_parallel_R7();
        t_oe_after_handoff_R5();
        t_midstream_reset_R1();
        t_refill_R8();
        go_hold();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule